// File: doc/BRIEF.md
# Virtual Address Segment Decoder

This block sorts each 64-bit virtual address into one of three routes: translation through the TLB, a direct window that needs no translation, or an illegal access. It is purely combinational. It takes the address, a write flag and the processor status bits: the two-bit privilege field, the exception-level and error-level flags, and the three 64-bit enables for user, supervisor and kernel. A direct route also returns the physical address. An illegal route returns a load or store address-error code.

The privilege field sets the effective privilege, but either exception flag forces kernel privilege. That privilege chooses which of the three 64-bit enables appears on the mode output. Before the window checks, a 32-bit address with bit 31 set and a zero upper word is sign-extended. The block does not perform the TLB lookup or decide cache behaviour. It only tells the pipeline where to send the access.

Top module: `va_seg_decoder`

## Requirements
- R1: Effective privilege is kernel when `privField` is 2'b00 or when `exlFlag` or `erlFlag` is 1. Otherwise it is supervisor for 2'b01 and user for 2'b10 or 2'b11. Only a non-kernel privilege can raise an address error.
- R2: `mode64` equals `kxEn` in kernel, `sxEn` in supervisor and `uxEn` in user privilege.
- R3: Every address from 0 to 0x7FFFFFFF asserts `useTlb`, in every privilege.
- R4: An address whose upper 32 bits are zero and whose bit 31 is set is handled as its sign-extended 64-bit value.
- R5: In kernel privilege, a sign-extended address from 0xFFFFFFFF80000000 to 0xFFFFFFFFBFFFFFFF asserts `directMap`. `physAddr` is then bits 28:0 of the address, zero-extended.
- R6: In kernel privilege, any other address above 0x7FFFFFFF that is not in the R8 window asserts `useTlb`.
- R7: In non-kernel privilege, an address above 0x7FFFFFFF that is not in the R8 window asserts `addrErr`. `errCode` is 4 for a read (`isWrite`=0) and 5 for a write. `errCode` is 0 whenever `addrErr` is 0.
- R8: When `WIDE_EN` is 1 and address bits 63:62 are 2'b10, `directMap` is asserted in any privilege. `physAddr` is then bits 43:0 of the address, zero-extended.
- R9: Exactly one of `useTlb`, `directMap` and `addrErr` is 1 for every input.
- R10: `physAddr` is zero whenever `directMap` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vaddr | input | 64 | Virtual address |
| isWrite | input | 1 | 1 for a store, 0 for a load |
| privField | input | 2 | Privilege field: 00 kernel, 01 supervisor, 10 user |
| exlFlag | input | 1 | Exception level, forces kernel |
| erlFlag | input | 1 | Error level, forces kernel |
| uxEn | input | 1 | 64-bit addressing enable, user |
| sxEn | input | 1 | 64-bit addressing enable, supervisor |
| kxEn | input | 1 | 64-bit addressing enable, kernel |
| useTlb | output | 1 | Access must be translated |
| directMap | output | 1 | Access bypasses translation |
| physAddr | output | 64 | Physical address for a direct access |
| addrErr | output | 1 | Illegal access |
| errCode | output | 4 | 4 load error, 5 store error, 0 none |
| mode64 | output | 1 | 64-bit mode for the effective privilege |

## Verification
The bench drives addresses just either side of the 0x7FFFFFFF boundary and both ends of the kernel direct window. A wrong range compare would send 0x80000000 to the TLB, or would treat 0xFFFFFFFFC0000000 as direct. It also drives a bare 32-bit address with bit 31 set in kernel privilege. A decoder that skipped sign extension would translate that address instead of mapping it directly.

A user-field access with an exception flag set checks that kernel privilege wins. Without the override, that access would be reported as an address error. The reserved field value and the supervisor field check the 64-bit enable choice. Addresses whose top bits are 10 are driven in user privilege, where a decoder that ordered the checks wrongly would raise an error instead of the wide direct mapping.

// File: rtl/vaseg_pkg.sv
package vaseg_pkg;
  typedef enum logic [1:0] {
    PRIV_KERNEL = 2'b00,
    PRIV_SUPER  = 2'b01,
    PRIV_USER   = 2'b10,
    PRIV_RSVD   = 2'b11
  } privField_e;

  // strobes from control to datapath
  typedef struct packed {
    logic routeTlb;
    logic mapKwin;
    logic mapWide;
    logic raiseErr;
  } segStrobe_t;

  localparam logic [3:0] ERR_CODE_NONE  = 4'd0;
  localparam logic [3:0] ERR_CODE_LOAD  = 4'd4;
  localparam logic [3:0] ERR_CODE_STORE = 4'd5;
endpackage

// File: rtl/va_seg_path.sv
module va_seg_path
  import vaseg_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int KWIN_BITS = 29,
  parameter int WIDE_BITS = 44,
  parameter bit WIDE_EN   = 1'b1
) (
  input  logic [ADDR_W-1:0] vaddr,
  input  segStrobe_t        strobe,
  output logic              lowHit,
  output logic              kwinHit,
  output logic              wideHit,
  output logic [ADDR_W-1:0] physAddr
);
  localparam int HALF = ADDR_W / 2;

  logic [ADDR_W-1:0] extAddr;

  // sign-extend a bare 32-bit address with its top bit set
  always_comb begin
    extAddr = vaddr;
    if (vaddr[ADDR_W-1:HALF] == '0 && vaddr[HALF-1])
      extAddr[ADDR_W-1:HALF] = '1;
  end

  assign lowHit  = (vaddr[ADDR_W-1:HALF-1] == '0);
  assign kwinHit = (&extAddr[ADDR_W-1:HALF]) && extAddr[HALF-1] && !extAddr[HALF-2];

  generate
    if (WIDE_EN) begin : g_wide
      assign wideHit = (vaddr[ADDR_W-1 -: 2] == 2'b10);
    end else begin : g_nowide
      assign wideHit = 1'b0;
    end
  endgenerate

  always_comb begin
    physAddr = '0;
    if (strobe.mapWide)
      physAddr[WIDE_BITS-1:0] = vaddr[WIDE_BITS-1:0];
    else if (strobe.mapKwin)
      physAddr[KWIN_BITS-1:0] = extAddr[KWIN_BITS-1:0];
  end

  always_comb begin
    AST_KWIN_IN_WINDOW: assert (!strobe.mapKwin || extAddr[HALF-1]); // R5
    AST_WIDE_TOP_BITS: assert (!strobe.mapWide || vaddr[ADDR_W-1 -: 2] == 2'b10); // R8
  end
endmodule

// File: rtl/va_seg_ctrl.sv
module va_seg_ctrl
  import vaseg_pkg::*;
(
  input  logic       isWrite,
  input  logic [1:0] privField,
  input  logic       exlFlag,
  input  logic       erlFlag,
  input  logic       uxEn,
  input  logic       sxEn,
  input  logic       kxEn,
  input  logic       lowHit,
  input  logic       kwinHit,
  input  logic       wideHit,
  output segStrobe_t strobe,
  output logic       mode64,
  output logic [3:0] errCode
);
  logic isKernel;
  privField_e privSel;

  assign privSel  = privField_e'(privField);
  assign isKernel = (privSel == PRIV_KERNEL) || exlFlag || erlFlag;

  always_comb begin
    if (isKernel)                mode64 = kxEn;
    else if (privSel == PRIV_SUPER) mode64 = sxEn;
    else                         mode64 = uxEn;
  end

  // priority: wide window, low range, kernel window, kernel mapped, error
  always_comb begin
    strobe = '0;
    if (wideHit)       strobe.mapWide  = 1'b1;
    else if (lowHit)   strobe.routeTlb = 1'b1;
    else if (isKernel) begin
      if (kwinHit) strobe.mapKwin  = 1'b1;
      else         strobe.routeTlb = 1'b1;
    end else           strobe.raiseErr = 1'b1;
  end

  assign errCode = !strobe.raiseErr ? ERR_CODE_NONE :
                   (isWrite ? ERR_CODE_STORE : ERR_CODE_LOAD);

  always_comb begin
    AST_ONE_ROUTE: assert ($countones(strobe) == 1); // R9
    AST_ERR_NEEDS_USER: assert (!strobe.raiseErr || !(privField == 2'b00 || exlFlag || erlFlag)); // R1
  end
endmodule

// File: rtl/va_seg_decoder.sv
module va_seg_decoder
  import vaseg_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int KWIN_BITS = 29,
  parameter int WIDE_BITS = 44,
  parameter bit WIDE_EN   = 1'b1
) (
  input  logic [ADDR_W-1:0] vaddr,
  input  logic              isWrite,
  input  logic [1:0]        privField,
  input  logic              exlFlag,
  input  logic              erlFlag,
  input  logic              uxEn,
  input  logic              sxEn,
  input  logic              kxEn,
  output logic              useTlb,
  output logic              directMap,
  output logic [ADDR_W-1:0] physAddr,
  output logic              addrErr,
  output logic [3:0]        errCode,
  output logic              mode64
);
  segStrobe_t strobe;
  logic lowHit, kwinHit, wideHit;

  va_seg_ctrl i_ctrl (
    .isWrite(isWrite), .privField(privField), .exlFlag(exlFlag), .erlFlag(erlFlag),
    .uxEn(uxEn), .sxEn(sxEn), .kxEn(kxEn),
    .lowHit(lowHit), .kwinHit(kwinHit), .wideHit(wideHit),
    .strobe(strobe), .mode64(mode64), .errCode(errCode)
  );

  va_seg_path #(
    .ADDR_W(ADDR_W), .KWIN_BITS(KWIN_BITS), .WIDE_BITS(WIDE_BITS), .WIDE_EN(WIDE_EN)
  ) i_path (
    .vaddr(vaddr), .strobe(strobe),
    .lowHit(lowHit), .kwinHit(kwinHit), .wideHit(wideHit), .physAddr(physAddr)
  );

  assign useTlb    = strobe.routeTlb;
  assign directMap = strobe.mapKwin | strobe.mapWide;
  assign addrErr   = strobe.raiseErr;

  always_comb begin
    AST_LOW_GOES_TLB: assert (!(vaddr[ADDR_W-1:31] == '0) || useTlb); // R3
    AST_CODE_ZERO_OK: assert (addrErr || errCode == 4'd0); // R7
    AST_PA_IDLE_ZERO: assert (directMap || physAddr == '0); // R10
  end
endmodule

// File: tb/test_va_seg_decoder.sv
module test_va_seg_decoder;
  typedef struct {
    string tag;
    logic tlb, dir, err, m64;
    logic [63:0] pa;
    logic [3:0] code;
  } expItem_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk; // 125 MHz

  logic [63:0] vaddr = '0;
  logic isWrite = 0, exlFlag = 0, erlFlag = 0, uxEn = 0, sxEn = 0, kxEn = 0;
  logic [1:0] privField = 2'b00;
  logic useTlb, directMap, addrErr, mode64;
  logic [63:0] physAddr;
  logic [3:0] errCode;

  int nChecks = 0, nFails = 0;
  bit driverDone = 0;
  expItem_t expQ[$];

  va_seg_decoder i_va_seg_decoder (
    .vaddr(vaddr), .isWrite(isWrite), .privField(privField), .exlFlag(exlFlag),
    .erlFlag(erlFlag), .uxEn(uxEn), .sxEn(sxEn), .kxEn(kxEn),
    .useTlb(useTlb), .directMap(directMap), .physAddr(physAddr),
    .addrErr(addrErr), .errCode(errCode), .mode64(mode64)
  );

  task automatic drive(input string tag, input logic [63:0] va, input logic wr,
                       input logic [1:0] pf, input logic ex, input logic er,
                       input logic ux, input logic sx, input logic kx,
                       input logic eTlb, input logic eDir, input logic [63:0] ePa,
                       input logic eErr, input logic [3:0] eCode, input logic eM64);
    expItem_t it;
    @(negedge clk);
    vaddr = va; isWrite = wr; privField = pf; exlFlag = ex; erlFlag = er;
    uxEn = ux; sxEn = sx; kxEn = kx;
    it.tag = tag; it.tlb = eTlb; it.dir = eDir; it.pa = ePa;
    it.err = eErr; it.code = eCode; it.m64 = eM64;
    expQ.push_back(it);
  endtask

  // monitor: compare at the edge following each drive
  always @(posedge clk) begin
    if (!rst && expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      nChecks++;
      if ({useTlb, directMap, addrErr, mode64, errCode, physAddr} !==
          {it.tlb, it.dir, it.err, it.m64, it.code, it.pa}) begin
        nFails++;
        $display("FAIL %s: got tlb=%b dir=%b err=%b m64=%b code=%0d pa=%h, expected tlb=%b dir=%b err=%b m64=%b code=%0d pa=%h",
                 it.tag, useTlb, directMap, addrErr, mode64, errCode, physAddr,
                 it.tlb, it.dir, it.err, it.m64, it.code, it.pa);
      end
      nChecks++;
      if ((useTlb + directMap + addrErr) != 1) begin
        nFails++;
        $display("FAIL R9 (%s): flags tlb=%b dir=%b err=%b, expected exactly one", it.tag, useTlb, directMap, addrErr);
      end
      nChecks++;
      if (!directMap && physAddr !== 64'd0) begin
        nFails++;
        $display("FAIL R10 (%s): pa=%h, expected 0", it.tag, physAddr);
      end
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    // reset-state inputs: kernel, address 0
    drive("R3 reset state", 64'h0, 0, 2'b00, 0, 0, 0, 0, 0, 1, 0, 64'h0, 0, 4'd0, 0);
    drive("R3 user top of low range", 64'h7FFF_FFFF, 0, 2'b10, 0, 0, 1, 0, 0, 1, 0, 64'h0, 0, 4'd0, 1);
    drive("R7 user read above low", 64'h8000_0000, 0, 2'b10, 0, 0, 0, 0, 0, 0, 0, 64'h0, 1, 4'd4, 0);
    drive("R7 user store high", 64'hFFFF_FFFF_C000_0000, 1, 2'b10, 0, 0, 0, 0, 0, 0, 0, 64'h0, 1, 4'd5, 0);
    drive("R2 supervisor sx", 64'h1_0000_0000, 1, 2'b01, 0, 0, 0, 1, 0, 0, 0, 64'h0, 1, 4'd5, 1);
    drive("R4 bare 32-bit kernel", 64'hA0AB_CDEF, 0, 2'b00, 0, 0, 0, 0, 0, 0, 1, 64'h00AB_CDEF, 0, 4'd0, 0);
    drive("R5 window top", 64'hFFFF_FFFF_BFFF_FFFF, 0, 2'b00, 0, 0, 0, 0, 0, 0, 1, 64'h1FFF_FFFF, 0, 4'd0, 0);
    drive("R5 window bottom", 64'hFFFF_FFFF_8000_0000, 1, 2'b00, 0, 0, 0, 0, 0, 0, 1, 64'h0, 0, 4'd0, 0);
    drive("R6 above window", 64'hFFFF_FFFF_C000_0000, 0, 2'b00, 0, 0, 0, 0, 0, 1, 0, 64'h0, 0, 4'd0, 0);
    drive("R6 kernel 1<<32", 64'h1_0000_0000, 0, 2'b00, 0, 0, 0, 0, 0, 1, 0, 64'h0, 0, 4'd0, 0);
    drive("R4 bare C0000000 kernel", 64'hC000_0000, 0, 2'b00, 0, 0, 0, 0, 0, 1, 0, 64'h0, 0, 4'd0, 0);
    drive("R6 kernel top 11", 64'hC000_0000_0000_0000, 0, 2'b00, 0, 0, 0, 0, 0, 1, 0, 64'h0, 0, 4'd0, 0);
    drive("R1 exl overrides user", 64'h8000_0000, 0, 2'b10, 1, 0, 1, 0, 0, 0, 1, 64'h0, 0, 4'd0, 0);
    drive("R1 erl overrides user", 64'hBFFF_FFFF, 1, 2'b10, 0, 1, 0, 0, 1, 0, 1, 64'h1FFF_FFFF, 0, 4'd0, 1);
    drive("R8 user wide window", 64'h9000_0000_1F60_0050, 1, 2'b10, 0, 0, 0, 0, 0, 0, 1, 64'h1F60_0050, 0, 4'd0, 0);
    drive("R8 kernel wide top", 64'hBFFF_FFFF_FFFF_FFFF, 0, 2'b00, 0, 0, 0, 0, 0, 0, 1, 64'h0FFF_FFFF_FFFF, 0, 4'd0, 0);
    drive("R2 reserved field uses ux", 64'h8000_0000, 0, 2'b11, 0, 0, 1, 1, 1, 0, 0, 64'h0, 1, 4'd4, 1);
    drive("R2 kernel kx", 64'h10, 0, 2'b00, 0, 0, 0, 0, 1, 1, 0, 64'h0, 0, 4'd0, 1);
    repeat (3) @(negedge clk);
    driverDone = 1;
  end

  initial begin
    fork
      begin wait (driverDone); end
      begin
        repeat (5000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule